// File: doc/BRIEF.md
# Trap Entry Status Controller

This block owns the processor status bits that change when control leaves the running program for the trap handler. When any trap cause is present, the block does three things in the same cycle. It raises a fetch redirect to the fixed handler vector and requests single-issue fetch for the handler. At the same clock edge it saves the old privilege and interrupt-enable state, records every cause that applies, captures the issue-mode context and loads the fault address. Causes come from software traps, a conditional overflow check, the floating-point unit, instruction and data access faults, and an external interrupt line.

The block also holds a lock watchdog. It counts retiring instructions after a lock instruction. If no unlock has retired within a fixed window, it raises an instruction trap. The handler returns through a restore strobe, which reloads the privilege, interrupt-enable and breakpoint-enable bits.

A three-state machine sequences the block:
- **BOOT** is the single cycle after reset. Redirect is raised with no trap bits, and causes are not taken.
- **RUN** is normal execution.
- **HANDLER** means a trap has been taken.

The transitions are:
- **boot_done**: BOOT to RUN, always.
- **trap_entry**: RUN or HANDLER to HANDLER, on any taken cause.
- **trap_return**: HANDLER to RUN, on restore with no cause present.

Top module: `trap_entry_ctrl`

## Requirements
- R1: On a taken trap, previous-user takes the old user bit and previous-interrupt takes the old interrupt-enable bit. Both are visible after the next clock edge.
- R2: On a taken trap, the user bit and the interrupt-enable bit are both cleared after the next clock edge.
- R3: On a taken trap, the dual-mode bit takes the value of `dual_i` in the trapping cycle.
- R4: On a taken trap, the mode-switch bit is set when `dual_i` differs from `next_dual_i`, and cleared when they are equal.
- R5: `trap_bits_o` records every applicable cause of the trapping cycle at once. The bit positions are: [0] instruction trap (software trap, overflow check, lock timeout), [1] interrupt, [2] instruction access, [3] data access, [4] floating point.
- R6: On a taken trap, the fault address is `pc_i` in single-issue mode. In dual-issue mode it is `pc_i` minus 4, the address of the floating-point half, because `pc_i` points at the core half.
- R7: An external interrupt causes a trap and sets bit [1] only while the interrupt-enable bit is 1. Otherwise it has no effect on redirect or on the status bits.
- R8: The overflow-check instruction traps only when `ovf_flag_i` is 1.
- R9: After a retiring lock, the 32nd later retiring non-unlock instruction raises an instruction trap with `lock_to_o` set. Cycles with `retire_i` low are not counted. `lock_to_o` is 0 after any other trap.
- R10: Reset gives one redirect cycle to 0xFFFFFF00 with `trap_bits_o` = 0. It clears the user, interrupt-enable and both breakpoint-enable bits.
- R11: `redirect_o` and `single_issue_o` go high in the same cycle as a taken cause, with `vector_o` = 0xFFFFFF00.
- R12: Restore without a cause reloads user, interrupt-enable and breakpoint enables, and returns to RUN (`in_handler_o` low). When a cause and restore coincide, the trap wins.
- R13: A retiring unlock disarms the watchdog, so no timeout follows however many instructions retire afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| retire_i | input | 1 | An instruction retires this cycle |
| lock_i | input | 1 | Retiring instruction is a lock |
| unlock_i | input | 1 | Retiring instruction is an unlock |
| sw_trap_i | input | 1 | Software trap instruction |
| ovf_chk_i | input | 1 | Overflow-check instruction executes |
| ovf_flag_i | input | 1 | Overflow flag |
| fp_fault_i | input | 1 | Floating-point fault |
| iacc_fault_i | input | 1 | Instruction access fault |
| dacc_fault_i | input | 1 | Data access fault |
| ext_int_i | input | 1 | External interrupt request |
| dual_i | input | 1 | Current instruction is dual-issue |
| next_dual_i | input | 1 | Next instruction is dual-issue |
| pc_i | input | 32 | Address of the current (core) instruction |
| restore_i | input | 1 | Handler return strobe |
| restore_user_i | input | 1 | User bit to restore |
| restore_ie_i | input | 1 | Interrupt-enable bit to restore |
| restore_brk_rd_i | input | 1 | Read-breakpoint enable to restore |
| restore_brk_wr_i | input | 1 | Write-breakpoint enable to restore |
| redirect_o | output | 1 | Redirect fetch to vector |
| vector_o | output | 32 | Handler vector address |
| single_issue_o | output | 1 | Handler fetch in single-issue mode |
| user_o | output | 1 | User-mode bit |
| ie_o | output | 1 | Interrupt-enable bit |
| prev_user_o | output | 1 | Saved user bit |
| prev_ie_o | output | 1 | Saved interrupt-enable bit |
| dim_o | output | 1 | Trapped in dual-issue mode |
| mode_sw_o | output | 1 | Issue mode was about to change |
| trap_bits_o | output | 5 | Recorded trap causes |
| lock_to_o | output | 1 | Lock watchdog expired |
| brk_rd_o | output | 1 | Read-breakpoint enable |
| brk_wr_o | output | 1 | Write-breakpoint enable |
| fir_o | output | 32 | Fault address |
| in_handler_o | output | 1 | State machine is in HANDLER |

## Verification
The redirect, vector and single-issue outputs are combinational. The bench drives a cause just after a rising edge and samples them a few nanoseconds later, in that same cycle. Every status output is one register away. The bench therefore advances exactly one rising edge and samples one nanosecond later, before it changes any input. The lock timeout shows up as a redirect in the same cycle as the 32nd counted retirement, so the bench checks that redirect stays low through the first 31 and is high on the 32nd. The boot redirect is checked in the first cycle after reset is released, and its absence is checked one cycle later.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int TRAP_W = 5;

    typedef struct packed {
        logic fp;
        logic dacc;
        logic iacc;
        logic intr;
        logic instr;
    } trap_bits_t;

    typedef enum logic [1:0] {
        ST_BOOT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_HANDLER = 2'd2
    } tctl_state_e;

endpackage

// File: rtl/trap_lock_watchdog.sv
module trap_lock_watchdog #(
    parameter int WINDOW = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic retire_i,
    input  logic lock_i,
    input  logic unlock_i,
    output logic timeout_o
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic          plain_retire;

    assign plain_retire = retire_i && !lock_i && !unlock_i;
    assign timeout_o    = armed_q && plain_retire && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (retire_i) begin
            if (lock_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (unlock_i) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (armed_q) begin
                if (cnt_q == LAST) begin
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_WDOG_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        armed_q |-> (32'(cnt_q) < WINDOW)); // R9
    AST_WDOG_UNLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        (retire_i && unlock_i && !lock_i) |=> !armed_q); // R13

endmodule

// File: rtl/trap_cause_decode.sv
module trap_cause_decode
    import trap_pkg::*;
(
    input  logic       sw_trap_i,
    input  logic       ovf_chk_i,
    input  logic       ovf_flag_i,
    input  logic       lock_to_i,
    input  logic       fp_fault_i,
    input  logic       iacc_fault_i,
    input  logic       dacc_fault_i,
    input  logic       ext_int_i,
    input  logic       ie_i,
    output trap_bits_t bits_o,
    output logic       take_o
);
    always_comb begin
        bits_o.instr = sw_trap_i || (ovf_chk_i && ovf_flag_i) || lock_to_i;
        bits_o.intr  = ext_int_i && ie_i;
        bits_o.iacc  = iacc_fault_i;
        bits_o.dacc  = dacc_fault_i;
        bits_o.fp    = fp_fault_i;
        take_o       = |bits_o;
    end

endmodule

// File: rtl/trap_status_regs.sv
module trap_status_regs
    import trap_pkg::*;
#(
    parameter int             AW     = 32,
    parameter logic [AW-1:0]  VECTOR = 'hFFFF_FF00
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          take_i,
    input  trap_bits_t    bits_i,
    input  logic          lock_to_i,
    input  logic          dual_i,
    input  logic          next_dual_i,
    input  logic [AW-1:0] pc_i,
    input  logic          restore_i,
    input  logic          restore_user_i,
    input  logic          restore_ie_i,
    input  logic          restore_brk_rd_i,
    input  logic          restore_brk_wr_i,
    output logic          redirect_o,
    output logic [AW-1:0] vector_o,
    output logic          user_o,
    output logic          ie_o,
    output logic          prev_user_o,
    output logic          prev_ie_o,
    output logic          dim_o,
    output logic          mode_sw_o,
    output trap_bits_t    bits_o,
    output logic          lock_to_o,
    output logic          brk_rd_o,
    output logic          brk_wr_o,
    output logic [AW-1:0] fir_o,
    output logic          in_handler_o
);
    localparam logic [AW-1:0] HALF_STEP = AW'(4);

    tctl_state_e   state_q, state_d;
    logic          take_ok;
    logic          user_q, ie_q, prev_user_q, prev_ie_q;
    logic          dim_q, mode_sw_q, lock_to_q, brk_rd_q, brk_wr_q;
    trap_bits_t    bits_q;
    logic [AW-1:0] fir_q;

    // Next-state process
    always_comb begin
        state_d = state_q;
        take_ok = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                state_d = ST_RUN;                 // boot_done
            end
            ST_RUN: begin
                take_ok = take_i;
                if (take_i) state_d = ST_HANDLER; // trap_entry
            end
            ST_HANDLER: begin
                take_ok = take_i;
                if (take_i)         state_d = ST_HANDLER; // trap_entry
                else if (restore_i) state_d = ST_RUN;     // trap_return
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // State and status registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= ST_BOOT;
            user_q      <= 1'b0;
            ie_q        <= 1'b0;
            prev_user_q <= 1'b0;
            prev_ie_q   <= 1'b0;
            dim_q       <= 1'b0;
            mode_sw_q   <= 1'b0;
            bits_q      <= '0;
            lock_to_q   <= 1'b0;
            brk_rd_q    <= 1'b0;
            brk_wr_q    <= 1'b0;
            fir_q       <= '0;
        end else begin
            state_q <= state_d;
            if (take_ok) begin
                prev_user_q <= user_q;
                prev_ie_q   <= ie_q;
                user_q      <= 1'b0;
                ie_q        <= 1'b0;
                dim_q       <= dual_i;
                mode_sw_q   <= dual_i ^ next_dual_i;
                bits_q      <= bits_i;
                lock_to_q   <= lock_to_i;
                fir_q       <= dual_i ? (pc_i - HALF_STEP) : pc_i;
            end else if (restore_i) begin
                user_q   <= restore_user_i;
                ie_q     <= restore_ie_i;
                brk_rd_q <= restore_brk_rd_i;
                brk_wr_q <= restore_brk_wr_i;
            end
        end
    end

    // Output process
    always_comb begin
        redirect_o   = (state_q == ST_BOOT) || take_ok;
        vector_o     = VECTOR;
        in_handler_o = (state_q == ST_HANDLER);
        user_o       = user_q;
        ie_o         = ie_q;
        prev_user_o  = prev_user_q;
        prev_ie_o    = prev_ie_q;
        dim_o        = dim_q;
        mode_sw_o    = mode_sw_q;
        bits_o       = bits_q;
        lock_to_o    = lock_to_q;
        brk_rd_o     = brk_rd_q;
        brk_wr_o     = brk_wr_q;
        fir_o        = fir_q;
    end

    AST_PREV_COPY: assert property (@(posedge clk_i) disable iff (rst_i)
        take_ok |=> (prev_user_q == $past(user_q)) && (prev_ie_q == $past(ie_q))); // R1
    AST_SUPERVISOR: assert property (@(posedge clk_i) disable iff (rst_i)
        take_ok |=> (!user_q && !ie_q)); // R2
    AST_DIM_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        take_ok |=> (dim_q == $past(dual_i))); // R3
    AST_MODE_SWITCH: assert property (@(posedge clk_i) disable iff (rst_i)
        take_ok |=> (mode_sw_q == ($past(dual_i) != $past(next_dual_i)))); // R4
    AST_INT_NEEDS_IE: assert property (@(posedge clk_i) disable iff (rst_i)
        take_ok |=> (!bits_q.intr || $past(ie_q))); // R7
    AST_BOOT_CLEAN: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_BOOT) |-> (bits_q == '0 && !user_q && !ie_q && !brk_rd_q && !brk_wr_q)); // R10
    AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_ok && restore_i) |=> (state_q == ST_HANDLER && !user_q)); // R12

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LOCK_WINDOW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          retire_i,
    input  logic          lock_i,
    input  logic          unlock_i,
    input  logic          sw_trap_i,
    input  logic          ovf_chk_i,
    input  logic          ovf_flag_i,
    input  logic          fp_fault_i,
    input  logic          iacc_fault_i,
    input  logic          dacc_fault_i,
    input  logic          ext_int_i,
    input  logic          dual_i,
    input  logic          next_dual_i,
    input  logic [AW-1:0] pc_i,
    input  logic          restore_i,
    input  logic          restore_user_i,
    input  logic          restore_ie_i,
    input  logic          restore_brk_rd_i,
    input  logic          restore_brk_wr_i,
    output logic          redirect_o,
    output logic [AW-1:0] vector_o,
    output logic          single_issue_o,
    output logic          user_o,
    output logic          ie_o,
    output logic          prev_user_o,
    output logic          prev_ie_o,
    output logic          dim_o,
    output logic          mode_sw_o,
    output logic [TRAP_W-1:0] trap_bits_o,
    output logic          lock_to_o,
    output logic          brk_rd_o,
    output logic          brk_wr_o,
    output logic [AW-1:0] fir_o,
    output logic          in_handler_o
);
    logic       wdog_to;
    logic       take;
    trap_bits_t cause_bits;
    trap_bits_t held_bits;

    trap_lock_watchdog #(.WINDOW(LOCK_WINDOW)) u_wdog (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .retire_i  (retire_i),
        .lock_i    (lock_i),
        .unlock_i  (unlock_i),
        .timeout_o (wdog_to)
    );

    trap_cause_decode u_decode (
        .sw_trap_i    (sw_trap_i),
        .ovf_chk_i    (ovf_chk_i),
        .ovf_flag_i   (ovf_flag_i),
        .lock_to_i    (wdog_to),
        .fp_fault_i   (fp_fault_i),
        .iacc_fault_i (iacc_fault_i),
        .dacc_fault_i (dacc_fault_i),
        .ext_int_i    (ext_int_i),
        .ie_i         (ie_o),
        .bits_o       (cause_bits),
        .take_o       (take)
    );

    trap_status_regs #(.AW(AW)) u_status (
        .clk_i            (clk_i),
        .rst_i            (rst_i),
        .take_i           (take),
        .bits_i           (cause_bits),
        .lock_to_i        (wdog_to),
        .dual_i           (dual_i),
        .next_dual_i      (next_dual_i),
        .pc_i             (pc_i),
        .restore_i        (restore_i),
        .restore_user_i   (restore_user_i),
        .restore_ie_i     (restore_ie_i),
        .restore_brk_rd_i (restore_brk_rd_i),
        .restore_brk_wr_i (restore_brk_wr_i),
        .redirect_o       (redirect_o),
        .vector_o         (vector_o),
        .user_o           (user_o),
        .ie_o             (ie_o),
        .prev_user_o      (prev_user_o),
        .prev_ie_o        (prev_ie_o),
        .dim_o            (dim_o),
        .mode_sw_o        (mode_sw_o),
        .bits_o           (held_bits),
        .lock_to_o        (lock_to_o),
        .brk_rd_o         (brk_rd_o),
        .brk_wr_o         (brk_wr_o),
        .fir_o            (fir_o),
        .in_handler_o     (in_handler_o)
    );

    assign trap_bits_o    = held_bits;
    assign single_issue_o = redirect_o;

    AST_TIMEOUT_TRAPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (wdog_to && !in_handler_o && !redirect_o) |-> 1'b0 || !wdog_to); // R9
    AST_LOCKTO_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (redirect_o && wdog_to) |=> (lock_to_o && trap_bits_o[0])); // R9

endmodule

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;
    localparam logic [31:0] VEC = 32'hFFFF_FF00;

    logic clk = 1'b0;
    logic rst;
    logic retire, lock, unlock, sw, ovc, ovf, fpf, iaf, daf, ext, dual, ndual;
    logic [31:0] pc;
    logic rs, rs_u, rs_ie, rs_br, rs_bw;
    logic redirect, single, user, ie, puser, pie, dim, msw, lto, brd, bwr, inh;
    logic [31:0] vector, fir;
    logic [4:0]  tbits;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    trap_entry_ctrl u_dut (
        .clk_i(clk), .rst_i(rst), .retire_i(retire), .lock_i(lock), .unlock_i(unlock),
        .sw_trap_i(sw), .ovf_chk_i(ovc), .ovf_flag_i(ovf), .fp_fault_i(fpf),
        .iacc_fault_i(iaf), .dacc_fault_i(daf), .ext_int_i(ext), .dual_i(dual),
        .next_dual_i(ndual), .pc_i(pc), .restore_i(rs), .restore_user_i(rs_u),
        .restore_ie_i(rs_ie), .restore_brk_rd_i(rs_br), .restore_brk_wr_i(rs_bw),
        .redirect_o(redirect), .vector_o(vector), .single_issue_o(single),
        .user_o(user), .ie_o(ie), .prev_user_o(puser), .prev_ie_o(pie), .dim_o(dim),
        .mode_sw_o(msw), .trap_bits_o(tbits), .lock_to_o(lto), .brk_rd_o(brd),
        .brk_wr_o(bwr), .fir_o(fir), .in_handler_o(inh)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        retire = 0; lock = 0; unlock = 0; sw = 0; ovc = 0; ovf = 0; fpf = 0;
        iaf = 0; daf = 0; ext = 0; dual = 0; ndual = 0; pc = '0;
        rs = 0; rs_u = 0; rs_ie = 0; rs_br = 0; rs_bw = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_restore(input logic u, input logic e, input logic br, input logic bw);
        rs = 1; rs_u = u; rs_ie = e; rs_br = br; rs_bw = bw;
        step();
        rs = 0; rs_u = 0; rs_ie = 0; rs_br = 0; rs_bw = 0;
    endtask

    task automatic do_reset();
        rst = 1; clear_in();
        repeat (3) @(posedge clk);
        #1 rst = 0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] exp_bits;
        logic       exp_take;
        bit         saw;
        do_reset();
        // R10: boot cycle
        #2;
        chk("R10", "boot redirect", 32'(redirect), 32'd1);
        chk("R10", "boot vector", vector, VEC);
        chk("R10", "boot bits", 32'(tbits), 32'd0);
        chk("R10", "boot user/ie", {30'd0, user, ie}, 32'd0);
        step();
        chk("R10", "redirect after boot", 32'(redirect), 32'd0);

        // R10: reset clears breakpoint enables
        do_restore(1, 1, 1, 1);
        chk("R12", "restore loads", {28'd0, user, ie, brd, bwr}, 32'hF);
        chk("R12", "restore stays run", 32'(inh), 32'd0);
        do_reset(); step();
        chk("R10", "reset clears u/ie/brk", {28'd0, user, ie, brd, bwr}, 32'h0);

        // R1-R8, R11: sweep of causes x user x ie x issue modes
        for (int idx = 0; idx < 2048; idx++) begin
            logic u, e, d, nd;
            u = idx[7]; e = idx[8]; d = idx[9]; nd = idx[10];
            do_restore(u, e, 0, 0);
            sw = idx[0]; ovc = idx[1]; ovf = idx[2]; fpf = idx[3];
            iaf = idx[4]; daf = idx[5]; ext = idx[6];
            dual = d; ndual = nd; pc = 32'h2000_0004 + 32'(idx) * 8;
            exp_bits = {idx[3], idx[5], idx[4], idx[6] & e, idx[0] | (idx[1] & idx[2])};
            exp_take = |exp_bits;
            #2;
            chk(exp_take ? "R11" : "R7/R8", "redirect", 32'(redirect), 32'(exp_take));
            if (exp_take) begin
                chk("R11", "single issue", 32'(single), 32'd1);
                chk("R11", "vector", vector, VEC);
            end
            step();
            sw = 0; ovc = 0; ovf = 0; fpf = 0; iaf = 0; daf = 0; ext = 0;
            if (exp_take) begin
                chk("R1", "prev user/ie", {30'd0, puser, pie}, {30'd0, u, e});
                chk("R2", "user/ie cleared", {30'd0, user, ie}, 32'd0);
                chk("R3", "dim", 32'(dim), 32'(d));
                chk("R4", "mode switch", 32'(msw), 32'(d ^ nd));
                chk("R5", "trap bits", 32'(tbits), 32'(exp_bits));
                chk("R6", "fir", fir, d ? pc - 32'd4 : pc);
                chk("R9", "no lock timeout flag", 32'(lto), 32'd0);
                chk("R12", "in handler", 32'(inh), 32'd1);
            end else begin
                chk("R7", "status unchanged", {30'd0, user, ie}, {30'd0, u, e});
                chk("R7", "still running", 32'(inh), 32'd0);
            end
        end

        // R12: trap wins over a coincident restore
        do_restore(1, 1, 0, 0);
        sw = 1; rs = 1; rs_u = 1; rs_ie = 1;
        step();
        clear_in();
        chk("R12", "trap wins user/ie", {30'd0, user, ie}, 32'd0);
        chk("R12", "trap wins prev", {30'd0, puser, pie}, 32'd3);
        chk("R12", "trap wins state", 32'(inh), 32'd1);

        // R9: lock window with idle gaps
        do_restore(0, 0, 0, 0);
        retire = 1; lock = 1; step(); lock = 0;
        saw = 0;
        for (int k = 1; k <= 31; k++) begin
            retire = 1; #2;
            if (redirect) saw = 1;
            step();
            if (k % 7 == 0) begin retire = 0; #2; if (redirect) saw = 1; step(); end
        end
        chk("R9", "no early timeout", 32'(saw), 32'd0);
        retire = 1; #2;
        chk("R9", "timeout on 32nd", 32'(redirect), 32'd1);
        step(); retire = 0;
        chk("R9", "lock timeout flag", 32'(lto), 32'd1);
        chk("R9", "instruction bit", 32'(tbits), 32'd1);
        retire = 1; #2;
        chk("R9", "disarmed after timeout", 32'(redirect), 32'd0);
        step(); retire = 0;

        // R13: unlock disarms
        do_restore(0, 0, 0, 0);
        retire = 1; lock = 1; step(); lock = 0;
        for (int k = 0; k < 20; k++) step();
        unlock = 1; step(); unlock = 0;
        saw = 0;
        for (int k = 0; k < 40; k++) begin
            #2; if (redirect) saw = 1;
            step();
        end
        retire = 0;
        chk("R13", "no timeout after unlock", 32'(saw), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule